// File: doc/BRIEF.md
# Integer ALU with Selective Overflow

A combinational 32-bit integer arithmetic and logic unit for the execute stage of a small load/store core. Each evaluation takes an operation code and a first operand. The second operand is either another register value or a 16-bit immediate. The ALU returns a 32-bit result, an overflow flag and a zero flag. The immediate is widened inside the block. Whether it is widened with its sign or with zeros depends on the operation.

Addition and subtraction come in two forms. The trapping form raises the overflow flag on signed two's-complement overflow. The non-trapping form produces the same result bits and never raises the flag. The surrounding pipeline decides what a raised flag means. Set-less-than also comes in two forms, signed and unsigned. Immediate arithmetic covers subtraction of a constant through a negative immediate, so there is no separate subtract-immediate code. The zero flag lets the branch logic resolve equal and not-equal decisions from a subtraction.

Top module: `int_alu`

## Requirements
- R1: The trapping codes ADD (0), SUB (2) and ADDI (10) produce a+b, a-b and a+sext(imm). They raise ovf_o exactly when the true signed result does not fit in 32 bits.
- R2: The non-trapping codes ADDU (1), SUBU (3) and ADDIU (11) give the same result bits as their trapping counterparts. ovf_o stays 0 for them, and for every code other than 0, 2 and 10.
- R3: For ADDI (10), ADDIU (11), SLTI (14) and SLTIU (15), imm_i is sign-extended from bit 15 before use, and b_i has no effect.
- R4: For ANDI (12) and ORI (13), imm_i is zero-extended, so the upper 16 result bits are a_i's upper bits ANDed with 0 (ANDI) or passed through unchanged (ORI).
- R5: SLT (8) and SLTI (14) output 1 when a is less than the second operand as signed numbers, otherwise 0. Bits 31..1 are always 0.
- R6: SLTU (9) and SLTIU (15) compare as unsigned numbers. For a=FFFFFFFA and b=0000FFFA, SLT gives 1 and SLTU gives 0.
- R7: SLL (6) and SRL (7) shift a_i by shamt_i (0..31) and fill vacated positions with zeros. b_i and imm_i have no effect.
- R8: zero_o is 1 exactly when result_o is all zeros.
- R9: AND (4) and OR (5) output the bitwise AND and OR of a_i and b_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First register operand |
| b_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate field |
| shamt_i | input | 5 | Shift amount |
| result_o | output | 32 | Result |
| ovf_o | output | 1 | Signed overflow on trapping add/sub |
| zero_o | output | 1 | Result is zero |

## Verification
There is no register between any input and result_o, ovf_o or zero_o, so all three are due in the same cycle the inputs change, after propagation only. The bench drives the operands on the falling clock edge and samples two nanoseconds later, well before the next rising edge, so each check sees the settled outputs for exactly one stimulus. The overflow corner cases sit at the signed boundaries, and the comparison cases straddle the sign bit, where the signed and unsigned answers differ.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,  OP_ADDU  = 4'd1,  OP_SUB  = 4'd2,  OP_SUBU  = 4'd3,
    OP_AND   = 4'd4,  OP_OR    = 4'd5,  OP_SLL  = 4'd6,  OP_SRL   = 4'd7,
    OP_SLT   = 4'd8,  OP_SLTU  = 4'd9,  OP_ADDI = 4'd10, OP_ADDIU = 4'd11,
    OP_ANDI  = 4'd12, OP_ORI   = 4'd13, OP_SLTI = 4'd14, OP_SLTIU = 4'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    SEL_ARITH, SEL_AND, SEL_OR, SEL_SLL, SEL_SRL, SEL_LTS, SEL_LTU
  } res_sel_e;

  typedef struct packed {
    logic     use_imm;
    logic     imm_signed;
    logic     sub;
    logic     trap;
    res_sel_e sel;
  } alu_ctrl_t;
endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic             signed_i,
  output logic [XLEN-1:0]  imm_o
);
  localparam int PAD_W = XLEN - IMM_W;
  logic fill;
  assign fill  = signed_i & imm_i[IMM_W-1];
  assign imm_o = {{PAD_W{fill}}, imm_i};
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  output logic [XLEN-1:0] sum_o,
  output logic            ovf_o,
  output logic            lt_s_o,
  output logic            lt_u_o
);
  localparam int MSB = XLEN - 1;
  logic [XLEN-1:0] b_eff;
  logic [XLEN:0]   full;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{XLEN{1'b0}}, sub_i};
  assign sum_o = full[MSB:0];
  // same-sign inputs, different-sign result
  assign ovf_o  = (a_i[MSB] == b_eff[MSB]) && (full[MSB] != a_i[MSB]);
  // valid only while subtracting
  assign lt_s_o = full[MSB] ^ ovf_o;
  assign lt_u_o = ~full[XLEN];
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int XLEN = 32,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [SHW-1:0]  amt_i,
  output logic [XLEN-1:0] sll_o,
  output logic [XLEN-1:0] srl_o
);
  logic [XLEN-1:0] l_st [SHW+1];
  logic [XLEN-1:0] r_st [SHW+1];

  assign l_st[0] = a_i;
  assign r_st[0] = a_i;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int D = 2 ** s;
    assign l_st[s+1] = amt_i[s] ? {l_st[s][XLEN-1-D:0], {D{1'b0}}} : l_st[s];
    assign r_st[s+1] = amt_i[s] ? {{D{1'b0}}, r_st[s][XLEN-1:D]}    : r_st[s];
  end

  assign sll_o = l_st[SHW];
  assign srl_o = r_st[SHW];
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int SHW   = $clog2(XLEN)
) (
  input  logic [3:0]       op_i,
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [SHW-1:0]   shamt_i,
  output logic [XLEN-1:0]  result_o,
  output logic             ovf_o,
  output logic             zero_o
);
  alu_ctrl_t       ctrl;
  logic [XLEN-1:0] imm_ext, opnd_b, sum, sll_res, srl_res;
  logic            add_ovf, lt_s, lt_u;

  always_comb begin
    ctrl = '{use_imm: 1'b0, imm_signed: 1'b0, sub: 1'b0, trap: 1'b0, sel: SEL_ARITH};
    unique case (alu_op_e'(op_i))
      OP_ADD:   ctrl.trap = 1'b1;
      OP_ADDU:  ;
      OP_SUB:   begin ctrl.sub = 1'b1; ctrl.trap = 1'b1; end
      OP_SUBU:  ctrl.sub = 1'b1;
      OP_AND:   ctrl.sel = SEL_AND;
      OP_OR:    ctrl.sel = SEL_OR;
      OP_SLL:   ctrl.sel = SEL_SLL;
      OP_SRL:   ctrl.sel = SEL_SRL;
      OP_SLT:   begin ctrl.sub = 1'b1; ctrl.sel = SEL_LTS; end
      OP_SLTU:  begin ctrl.sub = 1'b1; ctrl.sel = SEL_LTU; end
      OP_ADDI:  begin ctrl.use_imm = 1'b1; ctrl.imm_signed = 1'b1; ctrl.trap = 1'b1; end
      OP_ADDIU: begin ctrl.use_imm = 1'b1; ctrl.imm_signed = 1'b1; end
      OP_ANDI:  begin ctrl.use_imm = 1'b1; ctrl.sel = SEL_AND; end
      OP_ORI:   begin ctrl.use_imm = 1'b1; ctrl.sel = SEL_OR; end
      OP_SLTI:  begin ctrl.use_imm = 1'b1; ctrl.imm_signed = 1'b1;
                      ctrl.sub = 1'b1; ctrl.sel = SEL_LTS; end
      OP_SLTIU: begin ctrl.use_imm = 1'b1; ctrl.imm_signed = 1'b1;
                      ctrl.sub = 1'b1; ctrl.sel = SEL_LTU; end
      default:  ;
    endcase
  end

  alu_imm_ext #(.XLEN(XLEN), .IMM_W(IMM_W)) u_ext (
    .imm_i(imm_i), .signed_i(ctrl.imm_signed), .imm_o(imm_ext)
  );

  assign opnd_b = ctrl.use_imm ? imm_ext : b_i;

  alu_addsub #(.XLEN(XLEN)) u_addsub (
    .a_i(a_i), .b_i(opnd_b), .sub_i(ctrl.sub),
    .sum_o(sum), .ovf_o(add_ovf), .lt_s_o(lt_s), .lt_u_o(lt_u)
  );

  alu_shift #(.XLEN(XLEN), .SHW(SHW)) u_shift (
    .a_i(a_i), .amt_i(shamt_i), .sll_o(sll_res), .srl_o(srl_res)
  );

  always_comb begin
    unique case (ctrl.sel)
      SEL_AND: result_o = a_i & opnd_b;
      SEL_OR:  result_o = a_i | opnd_b;
      SEL_SLL: result_o = sll_res;
      SEL_SRL: result_o = srl_res;
      SEL_LTS: result_o = {{(XLEN-1){1'b0}}, lt_s};
      SEL_LTU: result_o = {{(XLEN-1){1'b0}}, lt_u};
      default: result_o = sum;
    endcase
  end

  assign ovf_o  = ctrl.trap & add_ovf;
  assign zero_o = ~|result_o;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
  import int_alu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int SHW   = $clog2(XLEN)
) (
  input logic [3:0]       op_i,
  input logic [XLEN-1:0]  a_i,
  input logic [XLEN-1:0]  b_i,
  input logic [IMM_W-1:0] imm_i,
  input logic [SHW-1:0]   shamt_i,
  input logic [XLEN-1:0]  result_o,
  input logic             ovf_o,
  input logic             zero_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  always_comb begin
    // R2
    no_overflow_chk: assert (!ovf_o || op inside {OP_ADD, OP_SUB, OP_ADDI});
    // R5
    slt_bool_chk: assert (!(op inside {OP_SLT, OP_SLTU, OP_SLTI, OP_SLTIU})
                          || result_o[XLEN-1:1] == '0);
    // R4
    andi_upper_chk: assert (op != OP_ANDI || result_o[XLEN-1:IMM_W] == '0);
    // R7
    srl_fill_chk: assert (op != OP_SRL || shamt_i == '0 || !result_o[XLEN-1]);
    // R7
    sll_fill_chk: assert (op != OP_SLL || shamt_i == '0 || !result_o[0]);
    // R8
    zero_flag_chk: assert (zero_o == (result_o == '0));
  end
endmodule

bind int_alu int_alu_chk #(.XLEN(XLEN), .IMM_W(IMM_W), .SHW(SHW)) u_chk (
  .op_i(op_i), .a_i(a_i), .b_i(b_i), .imm_i(imm_i), .shamt_i(shamt_i),
  .result_o(result_o), .ovf_o(ovf_o), .zero_o(zero_o)
);

// File: tb/int_alu_tb_top.sv
`timescale 1ns/1ps
module int_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op;
  logic [31:0] a, b;
  logic [15:0] imm;
  logic [4:0]  sh;
  logic [31:0] res;
  logic        ovf, zf;
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  int_alu dut_i (
    .op_i(op), .a_i(a), .b_i(b), .imm_i(imm), .shamt_i(sh),
    .result_o(res), .ovf_o(ovf), .zero_o(zf)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  // drive on falling edge, sample 2 ns later
  task automatic drive(input logic [3:0] o, input logic [31:0] va, input logic [31:0] vb,
                       input logic [15:0] vi, input logic [4:0] vs);
    @(negedge clk);
    op = o; a = va; b = vb; imm = vi; sh = vs;
    #2;
  endtask

  task automatic t_reset;
    op = 4'd0; a = '0; b = '0; imm = '0; sh = '0;
    #2;
    chk("R8 reset result", res, 32'h0);
    chk("R8 reset zero", {31'b0, zf}, 32'd1);
    chk("R1 reset ovf", {31'b0, ovf}, 32'd0);
  endtask

  task automatic t_trap;
    drive(4'd0, 32'h7fffffff, 32'h1, 16'h0, 5'd0);
    chk("R1 add max+1", res, 32'h80000000);
    chk("R1 add ovf", {31'b0, ovf}, 32'd1);
    drive(4'd0, 32'd5, 32'd3, 16'h0, 5'd0);
    chk("R1 add small", res, 32'd8);
    chk("R1 add no ovf", {31'b0, ovf}, 32'd0);
    drive(4'd2, 32'h80000000, 32'h1, 16'h0, 5'd0);
    chk("R1 sub min-1", res, 32'h7fffffff);
    chk("R1 sub ovf", {31'b0, ovf}, 32'd1);
    drive(4'd2, 32'd5, 32'd7, 16'h0, 5'd0);
    chk("R1 sub neg", res, 32'hfffffffe);
    chk("R1 sub no ovf", {31'b0, ovf}, 32'd0);
    drive(4'd10, 32'h7ffffff0, 32'h0, 16'h0010, 5'd0);
    chk("R1 addi ovf", {31'b0, ovf}, 32'd1);
    drive(4'd0, 32'h80000000, 32'h80000000, 16'h0, 5'd0);
    chk("R1 add neg ovf", {31'b0, ovf}, 32'd1);
    chk("R8 wrap zero", {31'b0, zf}, 32'd1);
  endtask

  task automatic t_nontrap;
    drive(4'd1, 32'h7fffffff, 32'h1, 16'h0, 5'd0);
    chk("R2 addu result", res, 32'h80000000);
    chk("R2 addu ovf", {31'b0, ovf}, 32'd0);
    drive(4'd3, 32'h80000000, 32'h1, 16'h0, 5'd0);
    chk("R2 subu result", res, 32'h7fffffff);
    chk("R2 subu ovf", {31'b0, ovf}, 32'd0);
    drive(4'd11, 32'h7fffffff, 32'h0, 16'h0001, 5'd0);
    chk("R2 addiu result", res, 32'h80000000);
    chk("R2 addiu ovf", {31'b0, ovf}, 32'd0);
  endtask

  task automatic t_sext;
    drive(4'd10, 32'd10, 32'hdeadbeef, 16'hfff6, 5'd0);
    chk("R3 addi -10", res, 32'h0);
    chk("R8 zero after addi", {31'b0, zf}, 32'd1);
    drive(4'd11, 32'h0, 32'h12345678, 16'h8000, 5'd0);
    chk("R3 addiu sext", res, 32'hffff8000);
    chk("R8 nonzero", {31'b0, zf}, 32'd0);
  endtask

  task automatic t_zext;
    drive(4'd12, 32'hffffffff, 32'hffffffff, 16'h8001, 5'd0);
    chk("R4 andi", res, 32'h00008001);
    drive(4'd13, 32'h0, 32'hffffffff, 16'hffff, 5'd0);
    chk("R4 ori", res, 32'h0000ffff);
    drive(4'd13, 32'h12340000, 32'h0, 16'h00ff, 5'd0);
    chk("R4 ori upper kept", res, 32'h123400ff);
  endtask

  task automatic t_compare;
    drive(4'd8, 32'hfffffffa, 32'h0000fffa, 16'h0, 5'd0);
    chk("R5 slt signed", res, 32'd1);
    drive(4'd9, 32'hfffffffa, 32'h0000fffa, 16'h0, 5'd0);
    chk("R6 sltu unsigned", res, 32'd0);
    drive(4'd8, 32'd5, 32'd5, 16'h0, 5'd0);
    chk("R5 slt equal", res, 32'd0);
    drive(4'd8, 32'h7fffffff, 32'h80000000, 16'h0, 5'd0);
    chk("R5 slt extremes", res, 32'd0);
    drive(4'd14, 32'hfffffffe, 32'h0, 16'hffff, 5'd0);
    chk("R5 slti -2<-1", res, 32'd1);
    drive(4'd15, 32'd5, 32'h0, 16'hffff, 5'd0);
    chk("R6 sltiu sext max", res, 32'd1);
    drive(4'd9, 32'd1, 32'd2, 16'h0, 5'd0);
    chk("R6 sltu 1<2", res, 32'd1);
  endtask

  task automatic t_shift;
    drive(4'd6, 32'h80000001, 32'hffffffff, 16'hffff, 5'd1);
    chk("R7 sll 1", res, 32'h00000002);
    drive(4'd7, 32'h80000000, 32'hffffffff, 16'hffff, 5'd31);
    chk("R7 srl 31", res, 32'h00000001);
    drive(4'd6, 32'hcafef00d, 32'h0, 16'h0, 5'd0);
    chk("R7 sll 0", res, 32'hcafef00d);
    drive(4'd7, 32'hffffffff, 32'h12345678, 16'h0, 5'd4);
    chk("R7 srl 4", res, 32'h0fffffff);
  endtask

  task automatic t_logic;
    drive(4'd4, 32'hf0f0ff00, 32'h0ff0f0f0, 16'hffff, 5'd0);
    chk("R9 and", res, 32'h00f0f000);
    drive(4'd5, 32'hf0f0ff00, 32'h0ff0f0f0, 16'h0, 5'd0);
    chk("R9 or", res, 32'hfff0fff0);
    drive(4'd2, 32'h1234abcd, 32'h1234abcd, 16'h0, 5'd0);
    chk("R8 sub equal", {31'b0, zf}, 32'd1);
  endtask

  initial begin
    t_reset();
    @(posedge clk);
    rst_ni = 1'b1;
    t_trap();
    t_nontrap();
    t_sext();
    t_zext();
    t_compare();
    t_shift();
    t_logic();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got %0d exp <5000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule